// File: doc/BRIEF.md
# Bfloat16 Multiply, Float32 Accumulate Unit

This unit is the arithmetic cell of a mixed-precision matrix engine. Each accepted operation multiplies two bfloat16 operands and adds the product to a running single-precision accumulator held inside the unit. The significand product of two bfloat16 values has at most 16 bits, so it is kept exact and the only rounding happens once, when the sum is formed. Round to nearest, ties to even, is applied there. Both formats share an 8-bit exponent with bias 127, so no range conversion sits between the multiply and the add.

The work is split over three register stages. The first unpacks the fields and multiplies the significands. The second aligns the product against the accumulator and adds them. The third normalizes, rounds and writes the accumulator. The accumulator is read in the second stage, so a new operation can start every second cycle. A clear input returns the accumulator to +0.0 and drops any operation still in the pipe. Denormals are flushed to zero, and infinities and NaNs follow fixed rules with one canonical NaN.

Top module: `bf16_mac_f32`

## Requirements
- R1: After reset, or on the clock edge after `acc_clear` is high, `acc_out` is 0x00000000 and `acc_valid` is low.
- R2: An operation accepted at clock edge t updates `acc_out` at edge t+2 and raises `acc_valid` for exactly the cycle that follows that edge.
- R3: `op_valid` is accepted at an edge unless an operation was accepted at the edge before. A strobe in the cycle right after an accepted one is ignored. Operations offered two cycles apart are both accumulated in order.
- R4: An operand has its sign in bit 15, a biased exponent (bias 127) in bits 14:7 and a fraction in bits 6:0. The accumulator has its sign in bit 31, exponent in bits 30:23 and fraction in bits 22:0. The new accumulator is the exact sum of the old value and the exact product, rounded once to float32.
- R5: When the exact sum lies halfway between two float32 values, the result takes the one with an even fraction LSB.
- R6: An operand with exponent field 0 counts as zero of its sign. A zero product has sign a XOR b. When the product and the accumulator are both zero, the result is zero with the AND of their signs.
- R7: A sum that cancels exactly to zero from nonzero terms gives +0.0.
- R8: An operand with exponent 255 and fraction 0 is an infinity. An infinite product or accumulator gives an infinity of that sign, and adding a finite product to an infinite accumulator leaves it unchanged.
- R9: A NaN operand, an infinity times a zero, or the sum of opposite infinities gives 0x7FC00000. A NaN accumulator stays 0x7FC00000 until cleared. `acc_out` never holds any other NaN encoding.
- R10: A rounded sum whose biased exponent exceeds 254 gives infinity with the sign of the sum (0x7F800000 or 0xFF800000).
- R11: A rounded sum whose biased exponent falls below 1 gives zero with the sign of the sum. `acc_out` never holds a denormal.
- R12: A clear drops an operation in flight, so that operation raises no `acc_valid` and leaves the accumulator at zero. `op_valid` in a clear cycle is ignored. Apart from clears, `acc_out` changes only at edges that raise `acc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 16 | First bfloat16 operand |
| op_b | input | 16 | Second bfloat16 operand |
| op_valid | input | 1 | Operand pair present this cycle |
| acc_clear | input | 1 | Reset accumulator to +0.0 and flush pipeline |
| acc_out | output | 32 | Float32 accumulator value |
| acc_valid | output | 1 | One-cycle pulse when an operation has updated `acc_out` |

## Verification
The bench sweeps every fraction of one operand against a spread of fractions of the other, with mixed signs and exponents. It clears the accumulator every sixteen steps so that cancellations and carries across the normalization point both occur often. An alignment or sticky-bit slip would show up in this sweep as a value off by one unit in the last place. Directed cases then target ties, exact cancellation, signed-zero flushing, tiny products, overflow by product and by accumulation, and every infinity and NaN path. A design that rounded ties away from zero, lost the sign of a zero, kept a denormal or produced a non-canonical NaN would fail one of these cases. Timing cases place a strobe right behind an accepted one, two operations two cycles apart, and clears that arrive with or behind an operation. These would catch a design that double-counts, drops an operation, or lets a cancelled operation land.

// File: rtl/bf16_mac_f32.sv
module bf16_mac_f32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic        op_valid,
  input  logic        acc_clear,
  output logic [31:0] acc_out,
  output logic        acc_valid
);
  localparam int SIG_W = 25;
  localparam int EXT_W = SIG_W + 3;
  localparam int SUM_W = EXT_W + 1;
  localparam logic [31:0] QNAN = 32'h7FC00000;

  function automatic logic [4:0] lead_zeros(input logic [SUM_W-1:0] x);
    lead_zeros = 5'(SUM_W);
    for (int i = 0; i < SUM_W; i++)
      if (x[i]) lead_zeros = 5'(SUM_W - 1 - i);
  endfunction

  // stage 1: unpack and multiply
  logic v1;
  logic p_sign, p_zero, p_inf, p_nan;
  logic signed [10:0] p_exp;
  logic [15:0] p_sig;

  wire [7:0] ea = op_a[14:7];
  wire [7:0] eb = op_b[14:7];
  wire a_zero = ea == 8'd0;
  wire b_zero = eb == 8'd0;
  wire a_inf  = ea == 8'hFF && op_a[6:0] == 7'd0;
  wire b_inf  = eb == 8'hFF && op_b[6:0] == 7'd0;
  wire a_nan  = ea == 8'hFF && op_a[6:0] != 7'd0;
  wire b_nan  = eb == 8'hFF && op_b[6:0] != 7'd0;
  wire m_nan  = a_nan | b_nan | (a_inf & b_zero) | (b_inf & a_zero);
  wire m_inf  = (a_inf | b_inf) & ~m_nan;
  wire [15:0] raw = 16'({1'b1, op_a[6:0]}) * 16'({1'b1, op_b[6:0]});
  wire accept = op_valid & ~acc_clear & ~v1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      p_sign <= 1'b0; p_zero <= 1'b1; p_inf <= 1'b0; p_nan <= 1'b0;
      p_exp <= '0; p_sig <= '0;
    end else begin
      v1 <= accept;
      if (accept) begin
        p_sign <= op_a[15] ^ op_b[15];
        p_nan  <= m_nan;
        p_inf  <= m_inf;
        p_zero <= (a_zero | b_zero) & ~m_nan & ~m_inf;
        p_exp  <= 11'(ea) + 11'(eb) + 11'(raw[15]) - 11'd127;
        p_sig  <= raw[15] ? raw : {raw[14:0], 1'b0};
      end
    end
  end

  // stage 2: align and add
  logic v2, r_sign, r_nan, r_inf, r_inf_sign, r_both_zero, r_zero_sign;
  logic signed [10:0] r_exp;
  logic [SUM_W-1:0] r_sum;

  wire [7:0] acc_e = acc_out[30:23];
  wire acc_zero = acc_e == 8'd0;
  wire acc_inf  = acc_e == 8'hFF && acc_out[22:0] == 23'd0;
  wire acc_nan  = acc_e == 8'hFF && acc_out[22:0] != 23'd0;
  logic signed [10:0] acc_exp;
  assign acc_exp = {3'b000, acc_e};
  wire [SIG_W-1:0] acc_sig = acc_zero ? '0 : {1'b1, acc_out[22:0], 1'b0};
  wire [SIG_W-1:0] prd_sig = p_zero ? '0 : {p_sig, 9'd0};
  wire p_big = ~p_zero & (acc_zero | (p_exp > acc_exp) | (p_exp == acc_exp && prd_sig > acc_sig));

  logic signed [10:0] big_exp, sml_exp;
  assign big_exp = p_big ? p_exp : acc_exp;
  assign sml_exp = p_big ? acc_exp : p_exp;
  wire [SIG_W-1:0] big_sig = p_big ? prd_sig : acc_sig;
  wire [SIG_W-1:0] sml_sig = p_big ? acc_sig : prd_sig;
  wire big_sign = p_big ? p_sign : acc_out[31];
  wire sml_sign = p_big ? acc_out[31] : p_sign;

  logic signed [11:0] e_diff;
  assign e_diff = {big_exp[10], big_exp} - {sml_exp[10], sml_exp};
  wire [4:0] shamt = (e_diff < 12'sd0 || e_diff > 12'sd27) ? 5'd28 : e_diff[4:0];
  wire [EXT_W-1:0] sml_ext = {sml_sig, 3'b000};
  wire [EXT_W-1:0] lost    = sml_ext & ~({EXT_W{1'b1}} << shamt);
  wire [EXT_W-1:0] aligned = (sml_ext >> shamt) | {{(EXT_W-1){1'b0}}, |lost};
  wire [SUM_W-1:0] sum = (big_sign ^ sml_sign)
                       ? {1'b0, big_sig, 3'b000} - {1'b0, aligned}
                       : {1'b0, big_sig, 3'b000} + {1'b0, aligned};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0;
      r_sign <= 1'b0; r_nan <= 1'b0; r_inf <= 1'b0; r_inf_sign <= 1'b0;
      r_both_zero <= 1'b0; r_zero_sign <= 1'b0; r_exp <= '0; r_sum <= '0;
    end else begin
      v2 <= v1 & ~acc_clear;
      if (v1) begin
        r_nan       <= p_nan | acc_nan | (p_inf & acc_inf & (p_sign ^ acc_out[31]));
        r_inf       <= p_inf | acc_inf;
        r_inf_sign  <= p_inf ? p_sign : acc_out[31];
        r_both_zero <= p_zero & acc_zero;
        r_zero_sign <= p_sign & acc_out[31];
        r_sign      <= big_sign;
        r_exp       <= big_exp;
        r_sum       <= sum;
      end
    end
  end

  // stage 3: normalize and round
  wire [4:0] lz = lead_zeros(r_sum);
  wire [SUM_W-1:0] norm = r_sum << lz;
  wire [23:0] mant = norm[28:5];
  wire round_up = norm[4] & ((|norm[3:0]) | mant[0]);
  wire [24:0] rnd = {1'b0, mant} + {24'd0, round_up};
  wire [23:0] mant_f = rnd[24] ? rnd[24:1] : rnd[23:0];
  logic signed [11:0] ex;
  assign ex = {r_exp[10], r_exp} + 12'd1 - {7'd0, lz} + {11'd0, rnd[24]};

  logic [31:0] result;
  always_comb begin
    if (r_nan)                result = QNAN;
    else if (r_inf)           result = {r_inf_sign, 8'hFF, 23'd0};
    else if (r_both_zero)     result = {r_zero_sign, 31'd0};
    else if (r_sum == '0)     result = 32'd0;
    else if (ex < 12'sd1)     result = {r_sign, 31'd0};
    else if (ex > 12'sd254)   result = {r_sign, 8'hFF, 23'd0};
    else                      result = {r_sign, ex[7:0], mant_f[22:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_out   <= 32'd0;
      acc_valid <= 1'b0;
    end else begin
      acc_valid <= v2 & ~acc_clear;
      if (acc_clear)  acc_out <= 32'd0;
      else if (v2)    acc_out <= result;
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clear |=> (acc_out == 32'd0 && !acc_valid)); // R1
  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $past(op_valid, 3)); // R2
  AST_SPACED_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> !acc_valid); // R3
  AST_CANON_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_out[30:23] == 8'hFF && acc_out[22:0] != 23'd0) |-> acc_out == QNAN); // R9
  AST_NO_DENORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_out[30:23] == 8'd0) |-> acc_out[22:0] == 23'd0); // R11
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !$past(acc_clear)) |-> $stable(acc_out)); // R12
endmodule

// File: tb/bf16_mac_f32_tb_top.sv
`timescale 1ns/1ps
module bf16_mac_f32_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic op_valid = 1'b0, acc_clear = 1'b0;
  logic [31:0] acc_out;
  logic acc_valid;
  int checks = 0, failures = 0;
  logic [31:0] exp_acc = 32'd0;
  bit done = 0;

  always #2 clk = ~clk;

  bf16_mac_f32 dut_i (.clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .op_valid(op_valid), .acc_clear(acc_clear), .acc_out(acc_out), .acc_valid(acc_valid));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
    checks++;
    if (got !== want) begin
      failures++;
      $display("FAIL %s: got %08h expected %08h", req, got, want);
    end
  endtask

  function automatic real bf_mag(input logic [15:0] x);
    return real'(128 + int'(x[6:0])) * (2.0 ** real'(int'(x[14:7]) - 134));
  endfunction

  function automatic logic [31:0] round_f32(input real r);
    logic [63:0] b = $realtobits(r);
    int e = int'(b[62:52]) - 1023;
    logic [52:0] m = {1'b1, b[51:0]};
    logic [23:0] mt = m[52:29];
    logic [28:0] rem = m[28:0];
    int be;
    if (rem > 29'h10000000 || (rem == 29'h10000000 && mt[0])) begin
      logic [24:0] t = {1'b0, mt} + 25'd1;
      if (t[24]) begin mt = t[24:1]; e++; end
      else mt = t[23:0];
    end
    be = e + 127;
    if (be < 1) return {b[63], 31'd0};
    if (be > 254) return {b[63], 8'hFF, 23'd0};
    return {b[63], 8'(be), mt[22:0]};
  endfunction

  function automatic logic [31:0] model(input logic [31:0] acc, input logic [15:0] a, input logic [15:0] b);
    logic az = a[14:7] == 0, bz = b[14:7] == 0;
    logic ai = a[14:7] == 8'hFF && a[6:0] == 0, bi = b[14:7] == 8'hFF && b[6:0] == 0;
    logic an = a[14:7] == 8'hFF && a[6:0] != 0, bn = b[14:7] == 8'hFF && b[6:0] != 0;
    logic ps = a[15] ^ b[15];
    logic cz = acc[30:23] == 0;
    logic ci = acc[30:23] == 8'hFF && acc[22:0] == 0;
    logic cn = acc[30:23] == 8'hFF && acc[22:0] != 0;
    logic pn = an | bn | (ai & bz) | (bi & az);
    logic pi = (ai | bi) & ~pn;
    logic pz = (az | bz) & ~pn & ~pi;
    real pv, av, s;
    if (pn || cn || (pi && ci && ps != acc[31])) return 32'h7FC00000;
    if (pi) return {ps, 8'hFF, 23'd0};
    if (ci) return acc;
    if (pz && cz) return {ps & acc[31], 31'd0};
    pv = pz ? 0.0 : bf_mag(a) * bf_mag(b);
    if (ps) pv = -pv;
    av = cz ? 0.0 : real'(8388608 + int'(acc[22:0])) * (2.0 ** real'(int'(acc[30:23]) - 150));
    if (acc[31]) av = -av;
    s = pv + av;
    if (s == 0.0) return 32'd0;
    return round_f32(s);
  endfunction

  task automatic mac(input string req, input logic [15:0] a, input logic [15:0] b);
    exp_acc = model(exp_acc, a, b);
    @(negedge clk); op_a = a; op_b = b; op_valid = 1'b1;
    @(negedge clk); op_valid = 1'b0;
    @(negedge clk); check("R2 early", {31'd0, acc_valid}, 32'd0);
    @(negedge clk); check("R2 valid", {31'd0, acc_valid}, 32'd1);
    check(req, acc_out, exp_acc);
  endtask

  task automatic do_clear();
    @(negedge clk); acc_clear = 1'b1;
    @(negedge clk); acc_clear = 1'b0;
    exp_acc = 32'd0;
    check("R1 clear", acc_out, 32'd0);
  endtask

  initial begin
    #(4.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset acc", acc_out, 32'd0);
    check("R1 reset valid", {31'd0, acc_valid}, 32'd0);

    // R4 sweep: all fractions of a against a spread of b
    for (int fa = 0; fa < 128; fa++) begin
      for (int fb = 0; fb < 128; fb += 3) begin
        logic [7:0] ea = 8'(118 + fa % 12);
        logic [7:0] eb = 8'(122 + fb % 11);
        logic sa = 1'(fa) ^ 1'(fb >> 2);
        logic sb = 1'(fb >> 4);
        mac("R4", {sa, ea, 7'(fa)}, {sb, eb, 7'(fb)});
        if (((fa * 43 + fb) % 16) == 15) do_clear();
      end
    end

    // R5 ties to even
    do_clear();
    mac("R5 one", 16'h3F80, 16'h3F80);
    mac("R5 tie even", 16'h3380, 16'h3F80);
    check("R5 tie value", acc_out, 32'h3F800000);
    mac("R5 above half", 16'h3440, 16'h3F80);
    check("R5 up value", acc_out, 32'h3F800002);

    // R7 exact cancellation
    do_clear();
    mac("R7 set", 16'h3FC0, 16'h4040);
    mac("R7 cancel", 16'hBFC0, 16'h4040);
    check("R7 plus zero", acc_out, 32'h00000000);

    // R11 and R6 signed zero flush
    do_clear();
    mac("R11 neg tiny", 16'h8080, 16'h0080);
    check("R11 neg zero", acc_out, 32'h80000000);
    mac("R6 neg zero product", 16'h8000, 16'h3F80);
    check("R6 and sign", acc_out, 32'h80000000);
    mac("R6 denormal input", 16'h0005, 16'h3F80);
    check("R6 pos zero", acc_out, 32'h00000000);
    mac("R11 pos tiny", 16'h0080, 16'h0080);
    check("R11 pos zero", acc_out, 32'h00000000);

    // R10 overflow
    do_clear();
    mac("R10 product pos", 16'h7F00, 16'h4000);
    check("R10 pos inf", acc_out, 32'h7F800000);
    do_clear();
    mac("R10 product neg", 16'hFF00, 16'h4000);
    check("R10 neg inf", acc_out, 32'hFF800000);
    do_clear();
    mac("R10 big", 16'h7F7F, 16'h3F80);
    mac("R10 sum overflow", 16'h7F7F, 16'h3F80);
    check("R10 sum inf", acc_out, 32'h7F800000);

    // R8 infinity
    do_clear();
    mac("R8 inf operand", 16'h3F80, 16'hFF80);
    check("R8 neg inf", acc_out, 32'hFF800000);
    mac("R8 inf holds", 16'h4000, 16'h4000);
    check("R8 still inf", acc_out, 32'hFF800000);

    // R9 NaN cases
    mac("R9 opposite inf", 16'h7F80, 16'h3F80);
    check("R9 nan from inf sum", acc_out, 32'h7FC00000);
    mac("R9 sticky", 16'h3F80, 16'h3F80);
    check("R9 nan sticky", acc_out, 32'h7FC00000);
    do_clear();
    mac("R9 inf times zero", 16'h7F80, 16'h0000);
    check("R9 nan inf zero", acc_out, 32'h7FC00000);
    do_clear();
    mac("R9 nan operand", 16'h3F80, 16'hFF81);
    check("R9 nan canonical", acc_out, 32'h7FC00000);

    // R3 strobe right after an accepted one is ignored
    do_clear();
    exp_acc = model(exp_acc, 16'h3F80, 16'h4000);
    @(negedge clk); op_a = 16'h3F80; op_b = 16'h4000; op_valid = 1'b1;
    @(negedge clk); op_a = 16'h4100; op_b = 16'h4100;
    @(negedge clk); op_valid = 1'b0;
    @(negedge clk);
    check("R3 first valid", {31'd0, acc_valid}, 32'd1);
    check("R3 first only", acc_out, exp_acc);
    @(negedge clk); check("R3 no second pulse", {31'd0, acc_valid}, 32'd0);
    @(negedge clk); check("R3 ignored strobe", acc_out, exp_acc);

    // R3 two cycles apart, both counted
    exp_acc = model(exp_acc, 16'h3FC0, 16'h3F80);
    @(negedge clk); op_a = 16'h3FC0; op_b = 16'h3F80; op_valid = 1'b1;
    @(negedge clk); op_valid = 1'b0;
    @(negedge clk); op_a = 16'hC000; op_b = 16'h3E80; op_valid = 1'b1;
    @(negedge clk); op_valid = 1'b0;
    check("R3 spaced first", acc_out, exp_acc);
    exp_acc = model(exp_acc, 16'hC000, 16'h3E80);
    @(negedge clk); check("R3 gap", {31'd0, acc_valid}, 32'd0);
    @(negedge clk);
    check("R3 spaced second valid", {31'd0, acc_valid}, 32'd1);
    check("R3 spaced second", acc_out, exp_acc);

    // R12 clear cancels an operation in flight
    @(negedge clk); op_a = 16'h4000; op_b = 16'h4000; op_valid = 1'b1;
    @(negedge clk); op_valid = 1'b0; acc_clear = 1'b1;
    @(negedge clk); acc_clear = 1'b0;
    check("R12 cleared", acc_out, 32'd0);
    @(negedge clk);
    check("R12 no pulse", {31'd0, acc_valid}, 32'd0);
    check("R12 stays zero", acc_out, 32'd0);
    // R12 op_valid together with clear
    @(negedge clk); op_a = 16'h4000; op_b = 16'h4000; op_valid = 1'b1; acc_clear = 1'b1;
    @(negedge clk); op_valid = 1'b0; acc_clear = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R12 clear-cycle op no pulse", {31'd0, acc_valid}, 32'd0);
    check("R12 clear-cycle op ignored", acc_out, 32'd0);
    exp_acc = 32'd0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule